// File: doc/BRIEF.md
# Read/Write Grouping Mode Controller

This block holds the one read-or-write serving mode that every per-bank selector of a grouping memory scheduler consults. It keeps live totals of reads and writes waiting across all bank queues, fed by enqueue and dequeue pulses for each class. It also watches two per-bank indication vectors. One says that a read picked in read mode is blocked by an older write to the same row and column. The other says that a bank found nothing of the current class to serve.

The mode changes for three reasons. The class being served has drained everywhere while the other class still waits. A blocked read is reported while reading. A bank reports that it found nothing. In the last case the controller first gives every other bank one scheduling offer, one per cycle, in rising index order with wrap-around, starting at the bank after the reporter. It changes the mode once that sweep is complete. At most one mode change happens per clock.

Top module: `rw_group_mode`

## Requirements
- R1: After reset the mode is read (`readMode`=1), both pending counts are 0 and `offerVld` is 0.
- R2: An enqueue pulse raises its class count by one and a dequeue pulse lowers it by one, both one clock later. An enqueue and a dequeue of the same class in the same cycle leave the count unchanged.
- R3: A dequeue at count 0 leaves the count at 0. An enqueue at the maximum count (all ones, 63 with the default 6-bit width) leaves it at the maximum.
- R4: In write mode with a registered write count of 0 and a nonzero read count, the mode becomes read at the next clock.
- R5: In read mode with a registered read count of 0 and a nonzero write count, the mode becomes write at the next clock.
- R6: When both counts are 0, no sweep is active and no blocked-read indication is present, the mode holds in either mode.
- R7: Any set bit of `hazardVec` in read mode switches the mode to write at the next clock. In write mode `hazardVec` has no effect.
- R8: When no sweep is active and no other mode change is due, a set bit in `emptyVec` starts a sweep at the next clock. For NUM_BANKS-1 cycles `offerVld`=1 and `offerBank` takes the values origin+1, origin+2, … modulo NUM_BANKS. At the clock after the last offer, `offerVld` falls and the mode toggles.
- R9: If several `emptyVec` bits are set, the lowest index is the origin. `emptyVec` is ignored while a sweep is active.
- R10: A blocked-read or drain mode change during a sweep ends the sweep at once (`offerVld`=0), and no further toggle follows.
- R11: An `emptyVec` bit in the same cycle as a blocked-read or drain mode change starts no sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rdEnq | input | 1 | One read entered some bank queue |
| rdDeq | input | 1 | One read left some bank queue |
| wrEnq | input | 1 | One write entered some bank queue |
| wrDeq | input | 1 | One write left some bank queue |
| hazardVec | input | NUM_BANKS | Per bank: selected read blocked by an older same-address write |
| emptyVec | input | NUM_BANKS | Per bank: nothing of the current class found |
| readMode | output | 1 | 1 = read mode, 0 = write mode |
| rdPending | output | CNT_W | Reads waiting over all banks |
| wrPending | output | CNT_W | Writes waiting over all banks |
| offerVld | output | 1 | A sweep offer is being made this cycle |
| offerBank | output | $clog2(NUM_BANKS) | Bank receiving the current offer |

## Verification
The hardest situation to reach is a sweep that must end early. The stimulus has to hold both counts nonzero so that no drain change fires by itself. It then starts a sweep and injects a blocked-read indication partway through. After that it watches several idle cycles to confirm that no late toggle appears. Wrap-around of the offer order is reached by starting sweeps from the highest and second-highest banks. Count saturation is reached by driving enough enqueues to fill the counter.

// File: rtl/rw_group_pkg.sv
package rw_group_pkg;

  typedef enum logic {
    MODE_WRITE = 1'b0,
    MODE_READ  = 1'b1
  } modeT;

  // control -> datapath strobes
  typedef struct packed {
    logic sweepStart;    // capture origin bank, step := 1
    logic sweepAdvance;  // step := step + 1
  } grpStrobeT;

endpackage

// File: rtl/rw_group_datapath.sv
module rw_group_datapath
  import rw_group_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  localparam int BW       = $clog2(NUM_BANKS),
  localparam int SUM_W    = BW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           incVec,    // [0]=read, [1]=write
  input  logic [1:0]           decVec,
  input  logic [NUM_BANKS-1:0] emptyVec,
  input  grpStrobeT            strobes,
  output logic [CNT_W-1:0]     rdPending,
  output logic [CNT_W-1:0]     wrPending,
  output logic                 sweepLast,
  output logic [BW-1:0]        offerBank
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [BW-1:0]    LAST_STEP = BW'(NUM_BANKS - 1);

  logic [1:0][CNT_W-1:0] cntQ;

  // one saturating up/down counter per request class
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cntQ[g] <= '0;
      end else if (incVec[g] && !decVec[g] && cntQ[g] != CNT_MAX) begin
        cntQ[g] <= cntQ[g] + 1'b1;
      end else if (decVec[g] && !incVec[g] && cntQ[g] != '0) begin
        cntQ[g] <= cntQ[g] - 1'b1;
      end
    end
  end

  assign rdPending = cntQ[0];
  assign wrPending = cntQ[1];

  // lowest-index reporting bank becomes the sweep origin
  logic [BW-1:0] originNext;
  always_comb begin
    originNext = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (emptyVec[i]) originNext = BW'(i);
    end
  end

  logic [BW-1:0] originQ;
  logic [BW-1:0] stepQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      originQ <= '0;
      stepQ   <= '0;
    end else if (strobes.sweepStart) begin
      originQ <= originNext;
      stepQ   <= BW'(1);
    end else if (strobes.sweepAdvance) begin
      stepQ   <= stepQ + 1'b1;
    end
  end

  logic [SUM_W-1:0] sumRaw;
  logic [SUM_W-1:0] sumMod;
  always_comb begin
    sumRaw = {1'b0, originQ} + {1'b0, stepQ};
    sumMod = (sumRaw >= SUM_W'(NUM_BANKS)) ? sumRaw - SUM_W'(NUM_BANKS) : sumRaw;
  end

  assign offerBank = sumMod[BW-1:0];
  assign sweepLast = (stepQ == LAST_STEP);

endmodule

// File: rtl/rw_group_control.sv
module rw_group_control
  import rw_group_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] hazardVec,
  input  logic [NUM_BANKS-1:0] emptyVec,
  input  logic                 rdZero,
  input  logic                 wrZero,
  input  logic                 sweepLast,
  output logic                 readMode,
  output logic                 sweepBusy,
  output grpStrobeT            strobes
);

  modeT modeQ;
  logic busyQ;

  logic inRead;
  logic hazChg;
  logic drainChg;
  logic forcedChg;
  logic sweepEnd;

  always_comb begin
    inRead    = (modeQ == MODE_READ);
    hazChg    = inRead && (|hazardVec);
    drainChg  = inRead ? (rdZero && !wrZero) : (wrZero && !rdZero);
    forcedChg = hazChg || drainChg;
    sweepEnd  = busyQ && sweepLast;

    strobes.sweepStart   = !busyQ && !forcedChg && (|emptyVec);
    strobes.sweepAdvance = busyQ && !forcedChg && !sweepLast;
  end

  // every cause of a change means "leave the current mode", so one toggle covers all
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ <= MODE_READ;
    end else if (forcedChg || sweepEnd) begin
      modeQ <= inRead ? MODE_WRITE : MODE_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
    end else if (forcedChg || sweepEnd) begin
      busyQ <= 1'b0;
    end else if (strobes.sweepStart) begin
      busyQ <= 1'b1;
    end
  end

  assign readMode  = inRead;
  assign sweepBusy = busyQ;

endmodule

// File: rtl/rw_group_mode.sv
module rw_group_mode
  import rw_group_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rdEnq,
  input  logic                 rdDeq,
  input  logic                 wrEnq,
  input  logic                 wrDeq,
  input  logic [NUM_BANKS-1:0] hazardVec,
  input  logic [NUM_BANKS-1:0] emptyVec,
  output logic                 readMode,
  output logic [CNT_W-1:0]     rdPending,
  output logic [CNT_W-1:0]     wrPending,
  output logic                 offerVld,
  output logic [BW-1:0]        offerBank
);

  grpStrobeT strobes;
  logic      sweepLast;

  rw_group_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .CNT_W    (CNT_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .incVec   ({wrEnq, rdEnq}),
    .decVec   ({wrDeq, rdDeq}),
    .emptyVec (emptyVec),
    .strobes  (strobes),
    .rdPending(rdPending),
    .wrPending(wrPending),
    .sweepLast(sweepLast),
    .offerBank(offerBank)
  );

  rw_group_control #(
    .NUM_BANKS(NUM_BANKS)
  ) i_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .hazardVec(hazardVec),
    .emptyVec (emptyVec),
    .rdZero   (rdPending == '0),
    .wrZero   (wrPending == '0),
    .sweepLast(sweepLast),
    .readMode (readMode),
    .sweepBusy(offerVld),
    .strobes  (strobes)
  );

endmodule

// File: rtl/rw_group_mode_chk.sv
module rw_group_mode_chk #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rdEnq,
  input logic                 rdDeq,
  input logic                 wrEnq,
  input logic                 wrDeq,
  input logic [NUM_BANKS-1:0] hazardVec,
  input logic                 readMode,
  input logic [CNT_W-1:0]     rdPending,
  input logic [CNT_W-1:0]     wrPending,
  input logic                 offerVld,
  input logic [BW-1:0]        offerBank
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  rd_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEnq && !rdDeq && rdPending != CNT_MAX) |=> (rdPending == $past(rdPending) + 1'b1));

  // R2
  wr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEnq && wrDeq) |=> $stable(wrPending));

  // R3
  rd_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdDeq && !rdEnq && rdPending == '0) |=> (rdPending == '0));

  // R3
  wr_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEnq && !wrDeq && wrPending == CNT_MAX) |=> (wrPending == CNT_MAX));

  // R6
  idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdPending == '0 && wrPending == '0 && !offerVld && hazardVec == '0) |=> $stable(readMode));

  // R7
  hazard_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readMode && (|hazardVec)) |=> !readMode);

  // R8
  offer_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offerVld && $past(offerVld)) |->
      (int'(offerBank) == (int'($past(offerBank)) + 1) % NUM_BANKS));

  // R11
  hazard_no_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readMode && (|hazardVec)) |=> !offerVld);

endmodule

bind rw_group_mode rw_group_mode_chk #(
  .NUM_BANKS(NUM_BANKS),
  .CNT_W    (CNT_W)
) i_rw_group_mode_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdEnq    (rdEnq),
  .rdDeq    (rdDeq),
  .wrEnq    (wrEnq),
  .wrDeq    (wrDeq),
  .hazardVec(hazardVec),
  .readMode (readMode),
  .rdPending(rdPending),
  .wrPending(wrPending),
  .offerVld (offerVld),
  .offerBank(offerBank)
);

// File: tb/test_rw_group_mode.sv
`timescale 1ns/100ps
module test_rw_group_mode;

  localparam int NB = 4;
  localparam int CW = 6;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rdEnq = 1'b0, rdDeq = 1'b0, wrEnq = 1'b0, wrDeq = 1'b0;
  logic [NB-1:0] hazardVec = '0;
  logic [NB-1:0] emptyVec = '0;
  logic          readMode;
  logic [CW-1:0] rdPending, wrPending;
  logic          offerVld;
  logic [BW-1:0] offerBank;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  rw_group_mode #(.NUM_BANKS(NB), .CNT_W(CW)) i_rw_group_mode (
    .clk(clk), .rst_n(rst_n),
    .rdEnq(rdEnq), .rdDeq(rdDeq), .wrEnq(wrEnq), .wrDeq(wrDeq),
    .hazardVec(hazardVec), .emptyVec(emptyVec),
    .readMode(readMode), .rdPending(rdPending), .wrPending(wrPending),
    .offerVld(offerVld), .offerBank(offerBank)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // inputs held for exactly one rising edge; returns at the following falling edge
  task automatic pulse(input logic rE, input logic rD, input logic wE, input logic wD,
                       input logic [NB-1:0] haz, input logic [NB-1:0] emp);
    rdEnq = rE; rdDeq = rD; wrEnq = wE; wrDeq = wD; hazardVec = haz; emptyVec = emp;
    @(negedge clk);
    rdEnq = 0; rdDeq = 0; wrEnq = 0; wrDeq = 0; hazardVec = '0; emptyVec = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0;
    rdEnq = 0; rdDeq = 0; wrEnq = 0; wrDeq = 0; hazardVec = '0; emptyVec = '0;
    idle(2);
    rst_n = 1;
  endtask

  // both classes waiting so that no drain change fires by itself
  task automatic setupBoth();
    doReset();
    pulse(1, 0, 1, 0, '0, '0);
  endtask

  task automatic tReset();
    doReset();
    chk("R1", "readMode", readMode, 1);
    chk("R1", "rdPending", rdPending, 0);
    chk("R1", "wrPending", wrPending, 0);
    chk("R1", "offerVld", offerVld, 0);
  endtask

  task automatic tCount();
    doReset();
    pulse(1, 0, 0, 0, '0, '0);
    chk("R2", "rd after enq", rdPending, 1);
    pulse(1, 1, 0, 0, '0, '0);
    chk("R2", "rd after enq+deq", rdPending, 1);
    pulse(1, 0, 1, 0, '0, '0);
    chk("R2", "rd after 2nd enq", rdPending, 2);
    chk("R2", "wr after enq", wrPending, 1);
    pulse(0, 0, 1, 1, '0, '0);
    chk("R2", "wr after enq+deq", wrPending, 1);
    pulse(0, 1, 0, 0, '0, '0);
    chk("R2", "rd after deq", rdPending, 1);
  endtask

  task automatic tSat();
    doReset();
    pulse(0, 1, 0, 0, '0, '0);
    chk("R3", "rd deq at zero", rdPending, 0);
    for (int i = 0; i < 64; i++) pulse(0, 0, 1, 0, '0, '0);
    chk("R3", "wr saturated", wrPending, 63);
    pulse(0, 0, 1, 0, '0, '0);
    chk("R3", "wr enq at max", wrPending, 63);
  endtask

  task automatic tDrain();
    setupBoth();
    pulse(0, 1, 0, 0, '0, '0);
    chk("R5", "rd count drained", rdPending, 0);
    chk("R5", "mode before drain edge", readMode, 1);
    idle(1);
    chk("R5", "mode after read drain", readMode, 0);
    pulse(1, 0, 0, 0, '0, '0);
    pulse(0, 0, 0, 1, '0, '0);
    chk("R4", "wr count drained", wrPending, 0);
    chk("R4", "mode before drain edge", readMode, 0);
    idle(1);
    chk("R4", "mode after write drain", readMode, 1);
  endtask

  task automatic tIdle();
    doReset();
    idle(4);
    chk("R6", "read mode held when idle", readMode, 1);
    pulse(0, 0, 1, 0, '0, '0);
    idle(1);
    chk("R5", "mode with only writes", readMode, 0);
    pulse(0, 0, 0, 1, '0, '0);
    idle(3);
    chk("R6", "write mode held when idle", readMode, 0);
    chk("R6", "no offer when idle", offerVld, 0);
  endtask

  task automatic tHazard();
    setupBoth();
    pulse(0, 0, 0, 0, 4'b0100, '0);
    chk("R7", "hazard in read mode", readMode, 0);
    pulse(0, 0, 0, 0, 4'b1001, '0);
    chk("R7", "hazard in write mode ignored", readMode, 0);
    idle(2);
    chk("R7", "write mode kept", readMode, 0);
  endtask

  task automatic tSweep();
    setupBoth();
    pulse(0, 0, 0, 0, '0, 4'b0100);
    chk("R8", "offer valid", offerVld, 1);
    chk("R8", "first offer bank", offerBank, 3);
    chk("R8", "mode during sweep", readMode, 1);
    idle(1);
    chk("R8", "wrapped offer bank", offerBank, 0);
    idle(1);
    chk("R8", "third offer bank", offerBank, 1);
    chk("R8", "mode before sweep end", readMode, 1);
    idle(1);
    chk("R8", "offer ends", offerVld, 0);
    chk("R8", "toggle to write", readMode, 0);
    pulse(0, 0, 0, 0, '0, 4'b1000);
    chk("R8", "offer from top bank", offerBank, 0);
    idle(1);
    chk("R8", "second offer", offerBank, 1);
    idle(1);
    chk("R8", "third offer", offerBank, 2);
    idle(1);
    chk("R8", "toggle to read", readMode, 1);
    chk("R8", "offer ends again", offerVld, 0);
  endtask

  task automatic tSweepBusy();
    setupBoth();
    pulse(0, 0, 0, 0, '0, 4'b0110);
    chk("R9", "lowest origin wins", offerBank, 2);
    pulse(0, 0, 0, 0, '0, 4'b0001);
    chk("R9", "report during sweep ignored", offerBank, 3);
    idle(1);
    chk("R9", "sweep continues", offerBank, 0);
    idle(1);
    chk("R9", "single toggle", readMode, 0);
    idle(2);
    chk("R9", "no restarted sweep", offerVld, 0);
    chk("R9", "mode stays", readMode, 0);
  endtask

  task automatic tSweepAbort();
    setupBoth();
    pulse(0, 0, 0, 0, '0, 4'b0001);
    chk("R10", "sweep running", offerVld, 1);
    pulse(0, 0, 0, 0, 4'b0010, '0);
    chk("R10", "hazard switches mode", readMode, 0);
    chk("R10", "sweep aborted", offerVld, 0);
    idle(4);
    chk("R10", "no late toggle", readMode, 0);
    chk("R10", "offer stays low", offerVld, 0);
  endtask

  task automatic tBlocked();
    setupBoth();
    pulse(0, 0, 0, 0, 4'b0001, 4'b0010);
    chk("R11", "hazard wins", readMode, 0);
    chk("R11", "no sweep started", offerVld, 0);
    idle(3);
    chk("R11", "mode held", readMode, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    tReset();
    tCount();
    tSat();
    tDrain();
    tIdle();
    tHazard();
    tSweep();
    tSweepBusy();
    tSweepAbort();
    tBlocked();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule